// File: doc/BRIEF.md
# Low-Power Burst-and-Hold Scheduler

This block sits above the half-bridge gate sequencer of a resonant converter and chooses how switching is paced. At high load it leaves the sequencer running without pause. When the measured output-power code falls below a programmable threshold, it changes to a burst pattern. Each burst is a low-side, high-side, low-side group of half-cycles. A hold interval follows each burst, and during the hold the sequencer is parked. The hold lasts half the active time of the burst just finished, which gives a fixed two-thirds duty.

While the converter is in burst mode, the block selects a wider sense-voltage threshold pair, so each cycle carries more energy. This wider pair is the window code. The window code follows the power code, so it becomes narrower as load falls further, and the duty stays the same. A hold ends only when the sequencer reports that its tracked capacitor voltage state is valid. Switching then continues from that state, with no restart sequence. Return to continuous switching needs the power code to rise above the threshold plus a hysteresis margin. That return is taken only at the end of a hold, so no half-cycle is ever cut short.

Top module: `lpb_burst_sched`

## Requirements
- R1: After reset, and at any time the block is in high-power mode, `run_en` is 1, `lp_mode` is 0 and `win_sel` is 0.
- R2: Low-power mode is entered only on a cycle where `half_done` is 1 and `half_hs` is 1 (a high-side half-cycle just completed, encoding 1 = high side, 0 = low side) and `pwr_code < pwr_thr`. `lp_mode` is 1 from the next cycle.
- R3: A burst consists of three completions in the order low, high, low. `run_en` stays 1 through the whole burst and goes to 0 in the cycle after the third completion.
- R4: Let A be the number of cycles from the first burst cycle through the cycle of the third completion. The hold keeps `run_en` at 0 for floor(A/2) cycles.
- R5: A hold does not end while `cap_trk_ok` is 0. If that input is low for the first D hold cycles, the hold lasts max(floor(A/2), D+1) cycles.
- R6: In low-power mode, `win_sel` = 1 + min(`pwr_code` >> 5, 3) with the default parameters. It is never 0 in this mode. It is loaded only on mode entry and at each hold-to-burst transition, and it stays stable during a burst and its hold.
- R7: At the end of a hold, the block returns to high-power mode (`lp_mode` 0, `win_sel` 0) if `pwr_code > pwr_thr + pwr_hyst`. The sum saturates at the all-ones code. Otherwise a new burst starts, with `run_en` 1.
- R8: A power code above the exit level seen during a burst does not end low-power mode before the burst and its hold are complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_code | input | PWR_W | Measured output-power code |
| pwr_thr | input | PWR_W | Low-power entry threshold |
| pwr_hyst | input | PWR_W | Hysteresis margin added for exit |
| half_done | input | 1 | One-cycle pulse when a half-cycle completes |
| half_hs | input | 1 | Side of the completed half-cycle (1 = high side) |
| cap_trk_ok | input | 1 | Tracked capacitor voltage state valid for resume |
| run_en | output | 1 | 1 = sequencer may switch, 0 = hold |
| lp_mode | output | 1 | 1 = low-power burst mode |
| win_sel | output | WIN_W | Energy-per-cycle threshold pair selector (0 = nominal) |

## Verification
The in-RTL assertions check the following on every cycle:
- mode is never left early, either from a running burst or from a hold whose count has not run out;
- no hold ends while the tracked capacitor state is invalid;
- the half-cycle order inside a burst;
- the window code is non-zero and stable in low-power mode;
- the outputs in high-power mode.

Some behaviours can only be shown by the bench scenarios:
- the exact hold length, which is half of a burst length measured from the bench's own pulse timing;
- the window code levels at different power codes;
- the hysteresis band and its saturation;
- the refusal to enter on a low-side completion.

// File: rtl/lpb_pkg.sv
package lpb_pkg;

    typedef enum logic [1:0] {
        ST_HP    = 2'd0,
        ST_BURST = 2'd1,
        ST_HOLD  = 2'd2
    } lpb_state_e;

    // Decision flags from the power comparator
    typedef struct packed {
        logic enter;  // power below entry threshold
        logic leave;  // power above threshold plus margin
    } lpb_req_t;

    // Events of the scheduler towards the window register
    typedef struct packed {
        logic lp_load;  // entering a burst (from high power or from hold)
        logic lp_clr;   // returning to high power
    } lpb_evt_t;

    localparam int LPB_BURST_HALVES = 3;

endpackage

// File: rtl/lpb_pwr_cmp.sv
module lpb_pwr_cmp
    import lpb_pkg::*;
#(
    parameter int PWR_W = 8
) (
    input  logic [PWR_W-1:0] pwr_code,
    input  logic [PWR_W-1:0] pwr_thr,
    input  logic [PWR_W-1:0] pwr_hyst,
    output lpb_req_t         req
);
    logic [PWR_W:0]   exit_sum;
    logic [PWR_W-1:0] exit_lvl;

    always_comb begin
        exit_sum = {1'b0, pwr_thr} + {1'b0, pwr_hyst};
        // Saturate: an overflowing margin pins the exit level at full scale
        exit_lvl = exit_sum[PWR_W] ? {PWR_W{1'b1}} : exit_sum[PWR_W-1:0];
        req.enter = (pwr_code < pwr_thr);
        req.leave = (pwr_code > exit_lvl);
    end

endmodule

// File: rtl/lpb_hold_timer.sv
module lpb_hold_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // The current hold cycle is the last one owed
    assign expired = (cnt_q <= CNT_W'(1));

    assert_load_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
        load |-> (load_val != '0));

endmodule

// File: rtl/lpb_burst_fsm.sv
module lpb_burst_fsm
    import lpb_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  lpb_req_t   req,
    input  logic       half_done,
    input  logic       half_hs,
    input  logic       cap_trk_ok,
    output lpb_state_e state,
    output lpb_evt_t   evt
);
    localparam int HC_W = $clog2(LPB_BURST_HALVES + 1);
    localparam logic [HC_W-1:0] LAST_HALF = HC_W'(LPB_BURST_HALVES - 1);

    lpb_state_e       state_q, state_d;
    logic [HC_W-1:0]  half_cnt_q;
    logic [CNT_W-1:0] act_cnt_q;
    logic [CNT_W:0]   act_total;
    logic [CNT_W-1:0] hold_len;
    logic             burst_end;
    logic             hold_exp;
    logic             resume_ok;

    assign burst_end = (state_q == ST_BURST) && half_done && (half_cnt_q == LAST_HALF);
    assign act_total = {1'b0, act_cnt_q} + 1'b1;
    assign hold_len  = act_total[CNT_W:1];
    assign resume_ok = (state_q == ST_HOLD) && hold_exp && cap_trk_ok;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HP:    if (half_done && half_hs && req.enter) state_d = ST_BURST;
            ST_BURST: if (burst_end)                         state_d = ST_HOLD;
            ST_HOLD:  if (resume_ok) state_d = req.leave ? ST_HP : ST_BURST;
            default:  state_d = ST_HP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_HP;
            half_cnt_q <= '0;
            act_cnt_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_BURST && state_q != ST_BURST) begin
                half_cnt_q <= '0;
                act_cnt_q  <= '0;
            end else if (state_q == ST_BURST) begin
                if (act_cnt_q != {CNT_W{1'b1}}) act_cnt_q <= act_cnt_q + 1'b1;
                if (half_done) half_cnt_q <= half_cnt_q + 1'b1;
            end
        end
    end

    lpb_hold_timer #(.CNT_W(CNT_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .load     (burst_end),
        .load_val (hold_len),
        .tick     (state_q == ST_HOLD),
        .expired  (hold_exp)
    );

    always_comb begin
        evt.lp_load = (state_d == ST_BURST) && (state_q != ST_BURST);
        evt.lp_clr  = (state_d == ST_HP) && (state_q != ST_HP);
    end

    assign state = state_q;

    assert_entry_cond_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HP && !(half_done && half_hs && req.enter)) |=> state_q == ST_HP);

    assert_burst_order_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BURST && half_done) |-> (half_hs == (half_cnt_q == HC_W'(1))));

    assert_burst_whole_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BURST && !burst_end) |=> state_q == ST_BURST);

    assert_hold_min_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD && !hold_exp) |=> state_q == ST_HOLD);

    assert_cap_wait_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD && !cap_trk_ok) |=> state_q == ST_HOLD);

    assert_stay_lp_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD && !req.leave) |=> state_q != ST_HP);

endmodule

// File: rtl/lpb_win_sel.sv
module lpb_win_sel
    import lpb_pkg::*;
#(
    parameter int PWR_W     = 8,
    parameter int LVL_SHIFT = 5,
    parameter int NLVL      = 4,
    parameter int WIN_W     = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  lpb_evt_t         evt,
    input  logic             lp_active,
    input  logic [PWR_W-1:0] pwr_code,
    output logic [WIN_W-1:0] win_sel
);
    localparam logic [PWR_W-1:0] LVL_TOP = PWR_W'(NLVL - 1);

    function automatic logic [WIN_W-1:0] level_of(input logic [PWR_W-1:0] p);
        logic [PWR_W-1:0] s;
        s = p >> LVL_SHIFT;
        if (s > LVL_TOP) return WIN_W'(NLVL);
        return WIN_W'(s) + 1'b1;
    endfunction

    logic [WIN_W-1:0] win_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
        end else if (evt.lp_clr) begin
            win_q <= '0;
        end else if (evt.lp_load) begin
            win_q <= level_of(pwr_code);
        end
    end

    assign win_sel = win_q;

    assert_win_wide_R6: assert property (@(posedge clk) disable iff (rst)
        lp_active |-> win_q != '0);

    assert_win_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (lp_active && !evt.lp_load && !evt.lp_clr) |=> $stable(win_q));

endmodule

// File: rtl/lpb_burst_sched.sv
module lpb_burst_sched
    import lpb_pkg::*;
#(
    parameter int PWR_W     = 8,
    parameter int CNT_W     = 8,
    parameter int LVL_SHIFT = 5,
    parameter int NLVL      = 4,
    localparam int WIN_W    = $clog2(NLVL + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PWR_W-1:0] pwr_code,
    input  logic [PWR_W-1:0] pwr_thr,
    input  logic [PWR_W-1:0] pwr_hyst,
    input  logic             half_done,
    input  logic             half_hs,
    input  logic             cap_trk_ok,
    output logic             run_en,
    output logic             lp_mode,
    output logic [WIN_W-1:0] win_sel
);
    lpb_req_t   req;
    lpb_evt_t   evt;
    lpb_state_e state;

    lpb_pwr_cmp #(.PWR_W(PWR_W)) u_cmp (
        .pwr_code (pwr_code),
        .pwr_thr  (pwr_thr),
        .pwr_hyst (pwr_hyst),
        .req      (req)
    );

    lpb_burst_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .half_done  (half_done),
        .half_hs    (half_hs),
        .cap_trk_ok (cap_trk_ok),
        .state      (state),
        .evt        (evt)
    );

    lpb_win_sel #(
        .PWR_W     (PWR_W),
        .LVL_SHIFT (LVL_SHIFT),
        .NLVL      (NLVL),
        .WIN_W     (WIN_W)
    ) u_win (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .lp_active (state != ST_HP),
        .pwr_code  (pwr_code),
        .win_sel   (win_sel)
    );

    assign run_en  = (state != ST_HOLD);
    assign lp_mode = (state != ST_HP);

    assert_hp_outputs_R1: assert property (@(posedge clk) disable iff (rst)
        !lp_mode |-> (run_en && win_sel == '0));

    assert_no_mid_exit_R8: assert property (@(posedge clk) disable iff (rst)
        (lp_mode && run_en) |=> lp_mode);

endmodule

// File: tb/tb_lpb_burst_sched.sv
module tb_lpb_burst_sched;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 7;
    // pwr, lenA, lenB, lenC, capDelay, expHold, expLp, expWin
    localparam int VEC [0:NV-1][0:7] = '{
        '{ 90,  2,  3,  4, 0,  4, 1, 3},
        '{ 40,  5,  5,  5, 0,  7, 1, 2},
        '{ 10,  1,  1,  1, 0,  1, 1, 1},
        '{110,  4,  4,  4, 9, 10, 1, 4},
        '{120,  2,  2,  2, 0,  3, 1, 4},
        '{ 70, 10, 20, 30, 0, 30, 1, 3},
        '{130,  3,  2,  2, 0,  3, 0, 0}
    };

    logic       clk = 0;
    logic       rst = 1;
    logic [7:0] pwr_code = 0, pwr_thr = 100, pwr_hyst = 20;
    logic       half_done = 0, half_hs = 0, cap_trk_ok = 1;
    logic       run_en, lp_mode;
    logic [2:0] win_sel;

    int checks = 0, failures = 0, cyc = 0, burst_drop = 0;

    lpb_burst_sched dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            failures = failures + 1;
            $display("FAIL watchdog: actual=%0d expected=<50000 cycles", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One half-cycle of len clocks ending with a completion pulse
    task automatic half(input int len, input logic hs);
        for (int i = 0; i < len; i++) begin
            if (lp_mode && !run_en) burst_drop++;
            half_done = (i == len - 1);
            half_hs   = hs;
            @(negedge clk);
        end
        half_done = 0;
    endtask

    // Counts hold cycles; cap_trk_ok held low for the first d cycles
    task automatic hold_len(input int d, output int n);
        n = 0;
        while (!run_en && n < 500) begin
            cap_trk_ok = (n >= d);
            @(negedge clk);
            n++;
        end
        cap_trk_ok = 1;
    endtask

    int hl;
    int prev_win;

    initial begin
        @(negedge clk); @(negedge clk);
        chk("R1 reset run_en", run_en, 1);
        chk("R1 reset lp_mode", lp_mode, 0);
        chk("R1 reset win_sel", win_sel, 0);
        rst = 0;

        // R2: low power but low-side completion must not enter
        pwr_code = 50;
        half(2, 0);
        chk("R2 no entry on low side", lp_mode, 0);
        // R2: high-side completion but power equal to threshold
        pwr_code = 100;
        half(2, 1);
        chk("R2 no entry at threshold", lp_mode, 0);
        chk("R1 hp run_en", run_en, 1);
        // R2: valid entry
        pwr_code = 90;
        half(3, 1);
        chk("R2 entry lp_mode", lp_mode, 1);
        chk("R6 entry win_sel", win_sel, 3);
        chk("R3 burst start run_en", run_en, 1);

        prev_win = 3;
        for (int v = 0; v < NV; v++) begin
            pwr_code = VEC[v][0];
            burst_drop = 0;
            half(VEC[v][1], 0);
            chk("R6 win stable in burst", win_sel, prev_win);
            chk("R8 lp held in burst", lp_mode, 1);
            half(VEC[v][2], 1);
            half(VEC[v][3], 0);
            chk("R3 run_en kept through burst", burst_drop, 0);
            chk("R3 hold after third half", run_en, 0);
            chk("R6 win stable in hold", win_sel, prev_win);
            hold_len(VEC[v][4], hl);
            chk(VEC[v][4] != 0 ? "R5 hold with cap wait" : "R4 hold length", hl, VEC[v][5]);
            chk("R7 mode after hold", lp_mode, VEC[v][6]);
            chk("R6 win after hold", win_sel, VEC[v][7]);
            chk("R7 run_en after hold", run_en, 1);
            prev_win = VEC[v][7];
        end

        // R7 with saturating exit level: 250 + 20 pins at 255
        pwr_thr = 250;
        pwr_code = 240;
        half(2, 1);
        chk("R2 re-entry", lp_mode, 1);
        chk("R6 win top level", win_sel, 4);
        pwr_code = 255;
        half(1, 0); half(1, 1); half(1, 0);
        hold_len(0, hl);
        chk("R4 minimum hold", hl, 1);
        chk("R7 saturated exit level keeps lp", lp_mode, 1);

        // R1: reset while in low-power mode
        rst = 1;
        @(negedge clk);
        rst = 0;
        chk("R1 reset from lp lp_mode", lp_mode, 0);
        chk("R1 reset from lp win_sel", win_sel, 0);
        chk("R1 reset from lp run_en", run_en, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule